// File: doc/BRIEF.md
# Prioritized Interrupt Controller

The controller gathers up to `NSRC` level-sensitive request lines. It picks the single most urgent one and raises one interrupt toward the CPU. Each source has its own configuration word. The word holds a 4-bit priority, an enable, a polarity choice and a target select. Each of these fields carries a write-enable strobe in the same word, so software can change one field without a read-modify-write. A priority of zero keeps a source silent.

Each request input passes through a two-flop synchronizer. A source is pending when all of the following hold:
- its level is active at the chosen polarity;
- it is enabled;
- its priority is strictly above a programmable threshold;
- it targets the CPU (target 0).

Among the pending sources, the highest priority wins, and the lower index wins a tie. The winner is shown in a vector word built from a programmable table base and the winner's index times eight. When nothing is pending, the vector shows index 0, and software treats that as spurious.

Register map (word addresses, `ADDR_W`=8):
- Per-source words sit at address = source index.
- The threshold is at 0x80.
- The vector table base is at 0x81.
- The read-only vector is at 0x82.

Top module: `prio_intc`

## Requirements
- R1: After reset every configuration field, the threshold and the table base read as 0, `cpu_irq` is 0 and `vector` is 0.
- R2: In a source word, priority is bits 3:0, target is bits 9:8, enable is bit 16 and active-low polarity is bit 17. Each field is written only when its strobe is set in the same write: bit 28 for priority, bit 25 for target, bit 26 for enable, bit 27 for polarity. A read returns the stored fields, with bits 28:25 always 0.
- R3: Writing 0x1E000000 clears priority, target, enable and polarity together. Writing only bit 28 sets the priority to 0 and leaves the other fields unchanged.
- R4: A source is pending only when its input is active (high, or low when bit 17 is 1), it is enabled, and its priority is non-zero and above the threshold.
- R5: The threshold is bits 3:0 of address 0x80. A source with priority equal to the threshold is not pending. Threshold 0 admits every non-zero priority.
- R6: The pending source with the highest priority wins. Among equal priorities, the lowest index wins.
- R7: `vector` and a read of 0x82 return the table base (written at 0x81, low 10 bits forced to 0) OR'ed with the winner index shifted left by 3. The index is 0 when nothing is pending.
- R8: Source 0 is reserved. Its word reads 0, ignores writes, and never raises a request.
- R9: `cpu_irq` is 1 exactly when some target-0 source is pending. Sources with a non-zero target neither raise `cpu_irq` nor appear in the vector.
- R10: A change on a request input reaches `cpu_irq` and `vector` on the third rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NSRC | Asynchronous level request lines |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data (combinational) |
| cpu_irq | output | 1 | Interrupt to the CPU |
| vector | output | DATA_W | Table base plus winner index times eight |

## Verification
Two things can land in the same cycle: a configuration write that changes a pending source's priority, and arbitration among several requests. The bench provokes this by holding three sources active while it rewrites one priority at a time. It then judges the vector after each write: first the highest priority must win, then the lowest index among equal priorities. A second overlap is between the threshold write and pending evaluation. This is judged by moving the threshold across a live request and watching `cpu_irq` fall and rise.

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int NSRC   = 71,
  parameter int PRIO_W = 4,
  parameter int TGT_W  = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_in,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              cpu_irq,
  output logic [DATA_W-1:0] vector
);
  localparam int IDX_W    = $clog2(NSRC);
  localparam int BASE_LSB = IDX_W + 3;
  localparam int B_TGT = 8, B_EN = 16, B_POL = 17;
  localparam int S_TGT = 25, S_EN = 26, S_POL = 27, S_PRIO = 28;
  localparam logic [ADDR_W-1:0] A_THR  = ADDR_W'(1 << (ADDR_W-1));
  localparam logic [ADDR_W-1:0] A_BASE = A_THR + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_VEC  = A_THR + ADDR_W'(2);

  logic [NSRC-1:0]          sync1, sync2, en_q, pol_q, pend;
  logic [PRIO_W-1:0]        prio_q [NSRC];
  logic [TGT_W-1:0]         tgt_q  [NSRC];
  logic [PRIO_W-1:0]        thr_q;
  logic [DATA_W-1:BASE_LSB] base_q;
  logic [IDX_W-1:0]         win_idx;
  logic [PRIO_W-1:0]        win_prio;
  logic [IDX_W-1:0]         rd_idx;

  logic unused_wbits;
  assign unused_wbits = ^{bus_wdata[DATA_W-1:S_PRIO+1], bus_wdata[S_TGT-1:B_POL+1],
                          bus_wdata[B_EN-1:B_TGT+TGT_W], bus_wdata[B_TGT-1:PRIO_W]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= irq_in;
      sync2 <= sync1;
    end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (i == 0) begin : g_rsvd
      assign prio_q[i] = '0;
      assign tgt_q[i]  = '0;
      assign en_q[i]   = 1'b0;
      assign pol_q[i]  = 1'b0;
    end else begin : g_cfg
      wire sel = bus_we && (bus_addr == ADDR_W'(i));
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          prio_q[i] <= '0;
          tgt_q[i]  <= '0;
          en_q[i]   <= 1'b0;
          pol_q[i]  <= 1'b0;
        end else if (sel) begin
          if (bus_wdata[S_PRIO]) prio_q[i] <= bus_wdata[PRIO_W-1:0];
          if (bus_wdata[S_TGT])  tgt_q[i]  <= bus_wdata[B_TGT +: TGT_W];
          if (bus_wdata[S_EN])   en_q[i]   <= bus_wdata[B_EN];
          if (bus_wdata[S_POL])  pol_q[i]  <= bus_wdata[B_POL];
        end
    end
    assign pend[i] = (sync2[i] ^ pol_q[i]) & en_q[i] &
                     (prio_q[i] > thr_q) & (tgt_q[i] == '0);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      thr_q  <= '0;
      base_q <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_THR)  thr_q  <= bus_wdata[PRIO_W-1:0];
      if (bus_addr == A_BASE) base_q <= bus_wdata[DATA_W-1:BASE_LSB];
    end

  always_comb begin
    win_idx  = '0;
    win_prio = '0;
    for (int i = 1; i < NSRC; i++)
      if (pend[i] && prio_q[i] > win_prio) begin
        win_idx  = IDX_W'(i);
        win_prio = prio_q[i];
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cpu_irq <= 1'b0;
      vector  <= '0;
    end else begin
      cpu_irq <= |pend;
      vector  <= {base_q, win_idx, 3'b000};
    end

  assign rd_idx = bus_addr[IDX_W-1:0];

  always_comb begin
    bus_rdata = '0;
    if (bus_addr < ADDR_W'(NSRC)) begin
      bus_rdata[PRIO_W-1:0]     = prio_q[rd_idx];
      bus_rdata[B_TGT +: TGT_W] = tgt_q[rd_idx];
      bus_rdata[B_EN]           = en_q[rd_idx];
      bus_rdata[B_POL]          = pol_q[rd_idx];
    end else if (bus_addr == A_THR) begin
      bus_rdata[PRIO_W-1:0] = thr_q;
    end else if (bus_addr == A_BASE) begin
      bus_rdata[DATA_W-1:BASE_LSB] = base_q;
    end else if (bus_addr == A_VEC) begin
      bus_rdata = vector;
    end
  end
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
  parameter int NSRC   = 71,
  parameter int PRIO_W = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              cpu_irq,
  input logic [DATA_W-1:0] vector,
  input logic [PRIO_W-1:0] thr_q,
  input logic [DATA_W-1:0] base_word
);
  localparam int IDX_W    = $clog2(NSRC);
  localparam int BASE_LSB = IDX_W + 3;
  localparam logic [ADDR_W-1:0] A_THR = ADDR_W'(1 << (ADDR_W-1));

  AST_VEC_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    vector[2:0] == 3'b000); // R7
  AST_VEC_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    vector[DATA_W-1:BASE_LSB] == $past(base_word[DATA_W-1:BASE_LSB])); // R7
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    vector[BASE_LSB-1:3] < IDX_W'(NSRC)); // R8
  AST_IRQ_HAS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq == (vector[BASE_LSB-1:3] != '0)); // R9
  AST_THR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_THR) |=> thr_q == $past(bus_wdata[PRIO_W-1:0])); // R5
  AST_STROBE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr < ADDR_W'(NSRC)) |-> bus_rdata[28:25] == 4'b0000); // R2
  AST_SRC0_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == '0) |-> bus_rdata == '0); // R8
endmodule

bind prio_intc prio_intc_chk #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .cpu_irq(cpu_irq), .vector(vector), .thr_q(thr_q),
  .base_word({base_q, {(IDX_W+3){1'b0}}}));

// File: tb/prio_intc_test.sv
module prio_intc_test;
  localparam int NSRC = 71;
  localparam logic [31:0] SP = 32'h1000_0000, SE = 32'h0400_0000,
                          SL = 32'h0800_0000, ST = 32'h0200_0000,
                          EN = 32'h0001_0000, CLR = 32'h1E00_0000;

  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [NSRC-1:0] irq_in = '0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, vector;
  logic cpu_irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prio_intc uut (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_irq(cpu_irq), .vector(vector));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    bus_addr = a; #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic prog(int s, int p, bit lo, int tgt);
    wr(8'(s), SP | SE | SL | ST | EN | (32'(lo) << 17) | (32'(tgt) << 8) | 32'(p));
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cleanup();
    foreach (irq_in[i]) if (i > 0) wr(8'(i), CLR);
    irq_in = '0;
    wr(8'h80, 0);
    settle();
  endtask

  task automatic t_reset();
    check("R1 irq", 32'(cpu_irq), 0);
    check("R1 vector", vector, 0);
    rd_chk("R1 src5", 8'd5, 0);
    rd_chk("R1 thr", 8'h80, 0);
    rd_chk("R1 base", 8'h81, 0);
  endtask

  task automatic t_strobes();
    wr(8'd3, 32'h0003_030F);
    rd_chk("R2 no strobe", 8'd3, 0);
    wr(8'd3, SP | 32'h5);
    rd_chk("R2 prio", 8'd3, 32'h5);
    wr(8'd3, SE | EN | 32'hF);
    rd_chk("R2 enable", 8'd3, 32'h0001_0005);
    wr(8'd3, SL | 32'h0002_0000);
    rd_chk("R2 polarity", 8'd3, 32'h0003_0005);
    wr(8'd3, ST | 32'h0000_0300);
    rd_chk("R2 target", 8'd3, 32'h0003_0305);
    wr(8'd3, SP);
    rd_chk("R3 prio only", 8'd3, 32'h0003_0300);
    wr(8'd3, CLR);
    rd_chk("R3 clear all", 8'd3, 0);
  endtask

  task automatic t_src0();
    wr(8'd0, SP | SE | EN | 32'hF);
    rd_chk("R8 read", 8'd0, 0);
    irq_in[0] = 1;
    settle();
    check("R8 no irq", 32'(cpu_irq), 0);
    irq_in[0] = 0;
  endtask

  task automatic t_pending();
    prog(10, 3, 0, 0);
    settle();
    check("R4 inactive", 32'(cpu_irq), 0);
    @(negedge clk); irq_in[10] = 1;
    repeat (2) @(posedge clk); @(negedge clk);
    check("R10 two edges", 32'(cpu_irq), 0);
    @(posedge clk); @(negedge clk);
    check("R10 third edge", 32'(cpu_irq), 1);
    check("R7 vector", vector, 32'h50);
    rd_chk("R7 read vec", 8'h82, 32'h50);
    wr(8'd10, SE);
    settle();
    check("R4 disabled", 32'(cpu_irq), 0);
    wr(8'd10, SE | EN | SL | 32'h0002_0000);
    settle();
    check("R4 low pol, high in", 32'(cpu_irq), 0);
    irq_in[10] = 0;
    settle();
    check("R4 low pol, low in", 32'(cpu_irq), 1);
    wr(8'd10, SP);
    settle();
    check("R4 prio zero", 32'(cpu_irq), 0);
    cleanup();
  endtask

  task automatic t_threshold();
    prog(10, 3, 0, 0);
    irq_in[10] = 1;
    wr(8'h80, 3);
    settle();
    check("R5 equal thr", 32'(cpu_irq), 0);
    wr(8'h80, 2);
    settle();
    check("R5 below thr", 32'(cpu_irq), 1);
    cleanup();
  endtask

  task automatic t_arbitrate();
    prog(20, 3, 0, 0); prog(40, 7, 0, 0); prog(60, 7, 0, 0);
    irq_in[20] = 1; irq_in[40] = 1; irq_in[60] = 1;
    settle();
    check("R6 tie high", vector, 32'h140);
    wr(8'd40, SP | 32'h2);
    settle();
    check("R6 highest", vector, 32'h1E0);
    wr(8'd60, SP | 32'h3);
    settle();
    check("R6 tie low", vector, 32'hA0);
    cleanup();
  endtask

  task automatic t_base();
    wr(8'h81, 32'hABCD_1234);
    rd_chk("R7 base read", 8'h81, 32'hABCD_1000);
    settle();
    check("R7 idle vec", vector, 32'hABCD_1000);
    prog(10, 3, 0, 0);
    irq_in[10] = 1;
    settle();
    check("R7 base vec", vector, 32'hABCD_1050);
    wr(8'h81, 0);
    cleanup();
  endtask

  task automatic t_target();
    prog(10, 9, 0, 1);
    irq_in[10] = 1;
    settle();
    check("R9 other target irq", 32'(cpu_irq), 0);
    check("R9 other target vec", vector, 0);
    prog(12, 2, 0, 0);
    irq_in[12] = 1;
    settle();
    check("R9 cpu target", vector, 32'h60);
    check("R9 irq", 32'(cpu_irq), 1);
    cleanup();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_strobes();
    t_src0();
    t_pending();
    t_threshold();
    t_arbitrate();
    t_base();
    t_target();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule